// File: doc/BRIEF.md
# Connection Memory Fill Controller

This block holds two connection memories, one for the local output port and one for the backplane output port, behind a small synchronous processor bus. It can also fill every location of both memories with a chosen bit pattern in a single hardware pass. This sets a switch to a known state at start-up far faster than writing one word at a time through the bus.

Software first sets an arm bit in the control register. It then writes the fill register with a 3-bit pattern for each memory and with the start bit set. The controller then walks every address and writes one word per clock into both memories in parallel. Each word carries its memory's pattern in the three most significant bits and zeros in all other bits. When the last address is written, the controller clears the start bit and raises a done flag. During the pass, all memory accesses from the bus are acknowledged but have no effect.

The bus address is `ADDR_W+2` bits wide. The top two bits select a region:
- `00`: registers. Address bit 0 picks the control register (0) or the fill register (1).
- `01`: unused. Reads return zero.
- `10`: local memory.
- `11`: backplane memory.

In the memory regions, the low `ADDR_W` bits give the word address.

Top module: `cmbf_top`

## Requirements
- R1: After reset, both registers read as zero, `fill_busy` and `fill_done` are low, and a read of the unused region returns zero.
- R2: In the control register, only bit 4 (the arm bit) is stored, and all other bits read as zero. In the fill register, bit 0 is the start bit, bits 3:1 are the local pattern and bits 6:4 are the backplane pattern. Bits above 6 read as zero.
- R3: A fill register write with bit 0 set starts a pass only if the arm bit is already 1. If the arm bit is 0, the patterns are stored, the start bit stays 0 and `fill_busy` stays low.
- R4: After a pass, every word of the local memory holds the local pattern in bits 15:13 with bits 12:0 zero. Every word of the backplane memory likewise holds the backplane pattern.
- R5: `fill_busy` rises in the cycle after the starting write is accepted and stays high for exactly 2^`ADDR_W` cycles.
- R6: When `fill_busy` falls, `fill_done` is high and the start bit reads 0. `fill_done` stays high until the next pass starts, and it is low whenever `fill_busy` is high.
- R7: While `fill_busy` is high, memory reads and writes are acknowledged one cycle later. Reads return zero and writes leave the memory unchanged.
- R8: While `fill_busy` is high, register writes are ignored. Register reads still return the current contents.
- R9: Outside a pass, a memory write stores the full 16-bit word and a later read returns it. Every cycle with `bus_sel` high is followed by exactly one cycle with `bus_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W+2 | Region (top two bits) and offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| fill_busy | output | 1 | Fill pass in progress |
| fill_done | output | 1 | Last pass completed |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` carry known values in every cycle where `bus_sel` is high. They also assume that reset is not raised in the middle of a pass. The pass-length and start-cause properties rely on this, because they follow the pass from its first cycle. The stimulus drives every bus input on the falling edge, holds `bus_sel` for a single cycle with an idle cycle after it, and applies reset only once, at the start. The sweep runs a pass for each of the 64 pattern pairs on a 16-word configuration and reads back every word of both memories.

// File: rtl/cmbf_pkg.sv
package cmbf_pkg;
    localparam int DATA_W       = 16;
    localparam int PAT_W        = 3;
    localparam int CTRL_ARM_BIT = 4;
    localparam int NPORT        = 2;

    typedef enum logic [1:0] {
        RG_REGS  = 2'b00,
        RG_NONE  = 2'b01,
        RG_LOCAL = 2'b10,
        RG_BACK  = 2'b11
    } region_e;

    typedef struct packed {
        logic [PAT_W-1:0] back_pat;
        logic [PAT_W-1:0] local_pat;
        logic             start;
    } fillreg_t;

    localparam int FILLREG_W = $bits(fillreg_t);

    function automatic logic [DATA_W-1:0] fill_word(input logic [PAT_W-1:0] pat);
        return {pat, {(DATA_W-PAT_W){1'b0}}};
    endfunction
endpackage

// File: rtl/cmbf_regs.sv
module cmbf_regs
    import cmbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_fill,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fill_end,
    output logic              arm,
    output fillreg_t          fill_reg,
    output logic              start_pulse
);
    assign start_pulse = wr_fill && wdata[0] && arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm      <= 1'b0;
            fill_reg <= '0;
        end else begin
            if (wr_ctrl)
                arm <= wdata[CTRL_ARM_BIT];
            if (wr_fill) begin
                fill_reg.local_pat <= wdata[PAT_W:1];
                fill_reg.back_pat  <= wdata[2*PAT_W:PAT_W+1];
                fill_reg.start     <= wdata[0] && arm;
            end else if (fill_end) begin
                fill_reg.start <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmbf_seq.sv
module cmbf_seq #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fill_end,
    output logic [ADDR_W-1:0] waddr
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    assign fill_end = busy && (waddr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            waddr <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            waddr <= '0;
        end else if (busy) begin
            if (waddr == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                waddr <= waddr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmbf_cmem.sv
module cmbf_cmem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[addr] <= wdata;
        rdata <= store[addr];
    end
endmodule

// File: rtl/cmbf_top.sv
module cmbf_top
    import cmbf_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int BUS_AW = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              fill_busy,
    output logic              fill_done
);
    region_e           region;
    logic              accept;
    logic              wr_ctrl, wr_fill;
    logic              arm, start_pulse, fill_end;
    fillreg_t          fill_reg;
    logic [ADDR_W-1:0] fill_addr;
    logic [DATA_W-1:0] reg_word;
    logic [DATA_W-1:0] mem_rd [NPORT];

    region_e           region_q;
    logic              blocked_q;
    logic [DATA_W-1:0] reg_rd_q;

    assign region  = region_e'(bus_addr[BUS_AW-1 -: 2]);
    assign accept  = bus_sel && !fill_busy;
    assign wr_ctrl = accept && bus_wr && region == RG_REGS && !bus_addr[0];
    assign wr_fill = accept && bus_wr && region == RG_REGS &&  bus_addr[0];

    cmbf_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_ctrl),
        .wr_fill     (wr_fill),
        .wdata       (bus_wdata),
        .fill_end    (fill_end),
        .arm         (arm),
        .fill_reg    (fill_reg),
        .start_pulse (start_pulse)
    );

    cmbf_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_pulse),
        .busy     (fill_busy),
        .done     (fill_done),
        .fill_end (fill_end),
        .waddr    (fill_addr)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam region_e MY_RG = (p == 0) ? RG_LOCAL : RG_BACK;
        logic [PAT_W-1:0]  pat;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;

        assign pat   = (p == 0) ? fill_reg.local_pat : fill_reg.back_pat;
        assign we    = fill_busy || (accept && bus_wr && region == MY_RG);
        assign addr  = fill_busy ? fill_addr : bus_addr[ADDR_W-1:0];
        assign wdata = fill_busy ? fill_word(pat) : bus_wdata;

        cmbf_cmem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
            .clk   (clk),
            .we    (we),
            .addr  (addr),
            .wdata (wdata),
            .rdata (mem_rd[p])
        );
    end

    always_comb begin
        reg_word = '0;
        if (bus_addr[0])
            reg_word[FILLREG_W-1:0] = fill_reg;
        else
            reg_word[CTRL_ARM_BIT] = arm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            region_q  <= RG_NONE;
            blocked_q <= 1'b0;
            reg_rd_q  <= '0;
        end else begin
            bus_ack   <= bus_sel;
            region_q  <= region;
            blocked_q <= fill_busy;
            reg_rd_q  <= reg_word;
        end
    end

    always_comb begin
        unique case (region_q)
            RG_REGS:  bus_rdata = reg_rd_q;
            RG_LOCAL: bus_rdata = blocked_q ? '0 : mem_rd[0];
            RG_BACK:  bus_rdata = blocked_q ? '0 : mem_rd[1];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmbf_chk.sv
module cmbf_chk #(
    parameter int ADDR_W = 12,
    localparam int BUS_AW = ADDR_W + 2,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              bus_ack,
    input logic              fill_busy,
    input logic              fill_done
);
    logic [ADDR_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (fill_busy) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    // R9
    ack_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ack);

    // R9
    no_stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ack);

    // R5
    pass_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_busy) |-> run_len == (ADDR_W+1)'(DEPTH));

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_busy) |-> $past(bus_sel && bus_wr && bus_addr[BUS_AW-1 -: 2] == 2'b00
                                   && bus_addr[0] && bus_wdata[0]));

    // R6
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_busy) |-> fill_done);

    // R6
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill_busy && fill_done));

    // R7
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_sel && fill_busy && bus_addr[BUS_AW-1])) |-> bus_rdata == 16'h0000);
endmodule

bind cmbf_top cmbf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .fill_busy (fill_busy),
    .fill_done (fill_done)
);

// File: tb/tb_cmbf_top.sv
module tb_cmbf_top;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int BAW   = AW + 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [BAW-1:0] bus_addr = '0;
    logic [15:0]    bus_wdata = '0;
    logic [15:0]    bus_rdata;
    logic           bus_ack, fill_busy, fill_done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cmbf_top #(.ADDR_W(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .fill_busy (fill_busy),
        .fill_done (fill_done)
    );

    function automatic logic [BAW-1:0] a_reg(input bit fill_sel);
        return {2'b00, {(AW-1){1'b0}}, fill_sel};
    endfunction
    function automatic logic [BAW-1:0] a_loc(input int w);
        return {2'b10, AW'(w)};
    endfunction
    function automatic logic [BAW-1:0] a_bck(input int w);
        return {2'b11, AW'(w)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [BAW-1:0] a, input logic [15:0] d,
                        output logic [15:0] q, output logic ak);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #2;
        ak = bus_ack;
        q  = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [BAW-1:0] a, input logic [15:0] d);
        logic [15:0] q; logic ak;
        xfer(1'b1, a, d, q, ak);
        check("R9 write ack", {15'd0, ak}, 16'd1);
    endtask

    task automatic rd(input logic [BAW-1:0] a, output logic [15:0] q);
        logic ak;
        xfer(1'b0, a, 16'h0000, q, ak);
        check("R9 read ack", {15'd0, ak}, 16'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] q;
        logic        ak;
        int          n;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 busy", {15'd0, fill_busy}, 16'd0);
        check("R1 done", {15'd0, fill_done}, 16'd0);
        rd(a_reg(0), q); check("R1 ctrl", q, 16'h0000);
        rd(a_reg(1), q); check("R1 fillreg", q, 16'h0000);
        rd({2'b01, AW'(3)}, q); check("R1 unused region", q, 16'h0000);

        // R3 start write while disarmed: patterns stored, no pass
        wr(a_reg(1), 16'h0035);
        check("R3 no busy", {15'd0, fill_busy}, 16'd0);
        rd(a_reg(1), q); check("R3 start bit clear", q, 16'h0034);
        check("R3 still idle", {15'd0, fill_busy}, 16'd0);

        // R2 register field layout
        wr(a_reg(0), 16'hFFFF);
        rd(a_reg(0), q); check("R2 ctrl arm only", q, 16'h0010);
        wr(a_reg(1), 16'hFF7E);
        rd(a_reg(1), q); check("R2 fillreg fields", q, 16'h007E);

        // R9 normal memory access
        wr(a_loc(7), 16'hA5C3);
        wr(a_bck(7), 16'h5A3C);
        rd(a_loc(7), q); check("R9 local word", q, 16'hA5C3);
        rd(a_bck(7), q); check("R9 backplane word", q, 16'h5A3C);

        // R4 R5 R6 sweep all pattern pairs
        for (int lp = 0; lp < 8; lp++) begin
            for (int bp = 0; bp < 8; bp++) begin
                wr(a_loc((lp + bp) % DEPTH), 16'h1FFF);
                wr(a_bck((lp * bp) % DEPTH), 16'hFFFF);
                xfer(1'b1, a_reg(1), {9'd0, 3'(bp), 3'(lp), 1'b1}, q, ak);
                n = 0;
                while (fill_busy && n < 4 * DEPTH) begin
                    n++;
                    @(posedge clk); #2;
                end
                check("R5 pass length", 16'(n), 16'(DEPTH));
                check("R6 done flag", {15'd0, fill_done}, 16'd1);
                rd(a_reg(1), q);
                check("R6 start cleared", q, {9'd0, 3'(bp), 3'(lp), 1'b0});
                for (int w = 0; w < DEPTH; w++) begin
                    rd(a_loc(w), q); check("R4 local fill", q, {3'(lp), 13'd0});
                    rd(a_bck(w), q); check("R4 backplane fill", q, {3'(bp), 13'd0});
                end
            end
        end

        // R7 R8 accesses during a pass
        xfer(1'b1, a_reg(1), 16'h0023, q, ak);
        check("R6 done cleared on start", {15'd0, fill_done}, 16'd0);
        repeat (4) @(posedge clk);
        xfer(1'b1, a_loc(0), 16'hFFFF, q, ak);
        check("R7 write acked", {15'd0, ak}, 16'd1);
        xfer(1'b0, a_bck(0), 16'h0000, q, ak);
        check("R7 read acked", {15'd0, ak}, 16'd1);
        check("R7 read zero", q, 16'h0000);
        wr(a_reg(0), 16'h0000);
        rd(a_reg(1), q); check("R8 fillreg readable", q, 16'h0023);
        check("R7 still busy", {15'd0, fill_busy}, 16'd1);
        n = 0;
        while (fill_busy && n < 4 * DEPTH) begin
            n++;
            @(posedge clk); #2;
        end
        rd(a_loc(0), q); check("R7 write ignored", q, 16'h2000);
        rd(a_bck(0), q); check("R7 backplane intact", q, 16'h4000);
        rd(a_reg(0), q); check("R8 ctrl write ignored", q, 16'h0010);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule